// File: doc/BRIEF.md
# Disk Adapter Host Register Front End

This block is the register face that a disk adapter shows to its host processor. The host reaches it through four byte offsets. Offset 0 is a 16-bit word port: the host writes command words there and reads status words back. Offset 2 takes basic control on write and returns the basic status byte on read. Offset 3 takes attention codes on write and returns the latched interrupt status byte on read. Offset 1 is not used.

Behind the registers sits a back-end port for an internal consumer. The consumer pulls command words one at a time and pushes status words into a single-word holding register. It also reports completion codes, and the block turns these into an interrupt carrying a status byte. A command may begin only after a command-request attention. That attention is refused while the adapter is busy or an interrupt is still pending. Full flags on the two holding registers pace every word in both directions.

A sticky protocol-error output records any host access that breaks these pacing rules, so the host's polling discipline can be checked.

Top module: `dskif_host_front`

## Requirements
- R1: Offset 0 writes the command register and reads the status word. Offset 2 writes control and reads basic status. Offset 3 writes attention and reads the interrupt status byte. Offset 1 reads as zero, and writing it changes nothing.
- R2: The basic status bits are: bit 7 DMA enable (control bit 1), bit 6 interrupt pending, bit 5 command in progress, bit 4 busy, bit 3 status word full, bit 2 command word full, bit 1 the back end's transfer request input, and bit 0 the interrupt line. Bits 15:8 read as zero.
- R3: A host write to offset 0 is taken only while a command is in progress and the command register is empty. A taken write sets command-full and presents the word to the back end until the back end takes it. Any other write to offset 0 is dropped and sets the protocol-error flag.
- R4: The high byte of the first command word sets the command length. A high byte of 0x46 (read 0x4601, write 0x4602) means 4 words; any other value (such as 0x0609 or 0x060A) means 2 words. The back end sees a first flag on word 0 and a last flag on the final word. Taking the final word clears command in progress.
- R5: The back end may push a status word only while `be_sts_ready` is high, which holds while the status register is empty. A push sets status-full. A host read of offset 0 returns the word and clears status-full.
- R6: A completion code sets interrupt pending and latches the interrupt status byte. The byte holds the command's device in bits 7:5, zero in bit 4 and the code in bits 3:0. Busy clears on every code except 0x0B (ready for data transfer).
- R7: Control bit 0 enables the interrupt line and control bit 1 sets the DMA enable bit. The line equals interrupt pending AND the enable, so writing 0 to control drops it.
- R8: An attention byte with action 0x01 in bits 4:0 requests a command. It is accepted only while neither busy nor interrupt pending. Acceptance sets busy and command in progress, and latches bits 7:5 as the device on `be_cmd_dev`. A refused request changes nothing else and sets the protocol-error flag.
- R9: Attention action 0x02 (end of interrupt) clears interrupt pending and drops the line. The interrupt status byte keeps its value.
- R10: Attention action 0x03 (abort) discards any partly received command and clears busy and command in progress. It pulses `be_abort` and raises a completion interrupt whose byte is the attention's device field OR 0x01.
- R11: The full attention byte 0xE4 clears busy, command in progress, both full flags, interrupt pending, the interrupt status byte, the control bits and the protocol-error flag.
- R12: A synchronous active-high `rst` puts the block into the same all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_sel | input | 1 | Host access strobe, one cycle per access |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 2 | Register offset |
| hst_wdata | input | 16 | Host write data (byte registers use bits 7:0) |
| hst_rdata | output | 16 | Host read data for the addressed offset |
| hst_irq | output | 1 | Interrupt line to the host |
| hst_proto_err | output | 1 | Sticky flag for a refused attention or dropped command word |
| be_cmd_valid | output | 1 | Command word held for the back end |
| be_cmd_word | output | 16 | Held command word |
| be_cmd_first | output | 1 | Held word is word 0 of the command |
| be_cmd_last | output | 1 | Held word is the final word of the command |
| be_cmd_dev | output | 3 | Device field of the accepted command request |
| be_cmd_take | input | 1 | Back end consumes the held command word |
| be_abort | output | 1 | Abort attention pulse |
| be_sts_valid | input | 1 | Back end pushes a status word |
| be_sts_word | input | 16 | Status word pushed |
| be_sts_ready | output | 1 | Status register empty |
| be_done_valid | input | 1 | Completion code strobe |
| be_done_code | input | 4 | Completion code |
| be_xfer_req | input | 1 | Transfer request shown in basic status bit 1 |

## Verification
Assertions in the RTL check several behaviours on every cycle. Each holding register keeps its word stable until it is consumed or read. Interrupt pending rises only on a completion or an abort. A command ends only when the back end takes a word flagged last. A refused attention always sets the protocol-error flag, and the 0xE4 byte always yields an all-zero status. Only the bench's scenarios show the remaining behaviours. These are the offset decoding and the exact bit layout of basic status, the command length chosen by each opcode, and the interrupt status byte across every device and completion code. They also cover the enable gating of the line and the flushing done by abort.

// File: rtl/dskif_pkg.sv
package dskif_pkg;

    localparam int DEV_W  = 3;
    localparam int CODE_W = 4;
    localparam int ACT_W  = 5;
    localparam int LEN_W  = 2;

    typedef enum logic [1:0] {
        OFS_WORD  = 2'd0,
        OFS_SPARE = 2'd1,
        OFS_CTRL  = 2'd2,
        OFS_ATTN  = 2'd3
    } ofs_e;

    typedef enum logic [ACT_W-1:0] {
        ACT_CMD   = 5'h01,
        ACT_EOI   = 5'h02,
        ACT_ABORT = 5'h03
    } act_e;

    localparam logic [7:0]        ATTN_RESET_BYTE = 8'hE4;
    localparam logic [CODE_W-1:0] CODE_DONE       = 4'h1;
    localparam logic [CODE_W-1:0] CODE_XFER_RDY   = 4'hB;
    localparam logic [7:0]        LONG_CMD_HI     = 8'h46;

    typedef struct packed {
        logic dma_en;
        logic int_pend;
        logic cmd_prog;
        logic busy;
        logic sts_full;
        logic cmd_full;
        logic xfer_req;
        logic irq;
    } bstat_t;

    function automatic logic [LEN_W-1:0] cmd_len_m1(input logic [7:0] op_hi);
        return (op_hi == LONG_CMD_HI) ? LEN_W'(3) : LEN_W'(1);
    endfunction

    function automatic logic [7:0] make_int_byte(input logic [DEV_W-1:0] dev,
                                                 input logic [CODE_W-1:0] code);
        return {dev, 1'b0, code};
    endfunction

endpackage

// File: rtl/dskif_cmd_path.sv
module dskif_cmd_path
    import dskif_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              start,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              take,
    output logic              full,
    output logic              in_prog,
    output logic [WORD_W-1:0] word,
    output logic              first,
    output logic              last,
    output logic              drop
);

    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] len_m1_q;
    logic [LEN_W-1:0] cur_len_m1;
    logic             accept;

    assign cur_len_m1 = (idx_q == '0) ? cmd_len_m1(word[WORD_W-1 -: 8]) : len_m1_q;
    assign first      = full && (idx_q == '0);
    assign last       = full && (idx_q == cur_len_m1);
    assign accept     = host_wr && in_prog && !full;
    assign drop       = host_wr && !accept;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            full     <= 1'b0;
            in_prog  <= 1'b0;
            idx_q    <= '0;
            len_m1_q <= '0;
            word     <= '0;
        end else begin
            if (start) begin
                in_prog <= 1'b1;
                idx_q   <= '0;
            end
            if (accept) begin
                word <= host_wdata;
                full <= 1'b1;
            end
            if (take && full) begin
                full <= 1'b0;
                if (idx_q == '0)
                    len_m1_q <= cur_len_m1;
                if (last) begin
                    in_prog <= 1'b0;
                    idx_q   <= '0;
                end else begin
                    idx_q <= idx_q + LEN_W'(1);
                end
            end
        end
    end

    assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (full && !take && !flush) |=> (full && $stable(word)));

    assert_len_end_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(in_prog) && !$past(flush)) |-> $past(take && last));

endmodule

// File: rtl/dskif_sts_path.sv
module dskif_sts_path #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic              full,
    output logic [WORD_W-1:0] word,
    output logic              ready
);

    assign ready = !full;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            full <= 1'b0;
            word <= '0;
        end else if (pop && full) begin
            full <= 1'b0;
        end else if (push && !full) begin
            full <= 1'b1;
            word <= push_word;
        end
    end

    assert_sts_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !flush) |=> (full && $stable(word)));

endmodule

// File: rtl/dskif_intr.sv
module dskif_intr
    import dskif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              done,
    input  logic [DEV_W-1:0]  done_dev,
    input  logic [CODE_W-1:0] done_code,
    input  logic              eoi,
    input  logic              int_en,
    output logic              pend,
    output logic [7:0]        stat_byte,
    output logic              irq
);

    assign irq = pend && int_en;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pend      <= 1'b0;
            stat_byte <= '0;
        end else if (done) begin
            pend      <= 1'b1;
            stat_byte <= make_int_byte(done_dev, done_code);
        end else if (eoi) begin
            pend <= 1'b0;
        end
    end

    assert_pend_src_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(done));

    assert_eoi_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (eoi && !done) |=> (!pend && !irq));

endmodule

// File: rtl/dskif_host_front.sv
module dskif_host_front
    import dskif_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_sel,
    input  logic              hst_wr,
    input  logic [1:0]        hst_addr,
    input  logic [WORD_W-1:0] hst_wdata,
    output logic [WORD_W-1:0] hst_rdata,
    output logic              hst_irq,
    output logic              hst_proto_err,
    output logic              be_cmd_valid,
    output logic [WORD_W-1:0] be_cmd_word,
    output logic              be_cmd_first,
    output logic              be_cmd_last,
    output logic [DEV_W-1:0]  be_cmd_dev,
    input  logic              be_cmd_take,
    output logic              be_abort,
    input  logic              be_sts_valid,
    input  logic [WORD_W-1:0] be_sts_word,
    output logic              be_sts_ready,
    input  logic              be_done_valid,
    input  logic [CODE_W-1:0] be_done_code,
    input  logic              be_xfer_req
);

    localparam int DEV_LSB = 8 - DEV_W;

    // host access decode
    logic wr_word, rd_word, wr_ctrl, wr_attn;
    assign wr_word = hst_sel &&  hst_wr && (hst_addr == OFS_WORD);
    assign rd_word = hst_sel && !hst_wr && (hst_addr == OFS_WORD);
    assign wr_ctrl = hst_sel &&  hst_wr && (hst_addr == OFS_CTRL);
    assign wr_attn = hst_sel &&  hst_wr && (hst_addr == OFS_ATTN);

    logic [ACT_W-1:0] act;
    logic [DEV_W-1:0] att_dev;
    logic att_rst, att_cmd, att_eoi, att_abort, cmd_ok, att_rej;
    assign act       = hst_wdata[ACT_W-1:0];
    assign att_dev   = hst_wdata[7:DEV_LSB];
    assign att_rst   = wr_attn && (hst_wdata[7:0] == ATTN_RESET_BYTE);
    assign att_cmd   = wr_attn && !att_rst && (act == ACT_CMD);
    assign att_eoi   = wr_attn && !att_rst && (act == ACT_EOI);
    assign att_abort = wr_attn && !att_rst && (act == ACT_ABORT);

    logic busy_q, pend;
    logic [DEV_W-1:0] dev_q;
    logic [1:0]       ctl_q;
    logic             perr_q;

    assign cmd_ok  = att_cmd && !busy_q && !pend;
    assign att_rej = att_cmd && !cmd_ok;

    // command holding path
    logic cmd_full, cmd_prog, cmd_drop;
    dskif_cmd_path #(.WORD_W(WORD_W)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .flush      (att_rst || att_abort),
        .start      (cmd_ok),
        .host_wr    (wr_word),
        .host_wdata (hst_wdata),
        .take       (be_cmd_take),
        .full       (cmd_full),
        .in_prog    (cmd_prog),
        .word       (be_cmd_word),
        .first      (be_cmd_first),
        .last       (be_cmd_last),
        .drop       (cmd_drop)
    );

    // status holding path
    logic             sts_full;
    logic [WORD_W-1:0] sts_word;
    dskif_sts_path #(.WORD_W(WORD_W)) u_sts (
        .clk       (clk),
        .rst       (rst),
        .flush     (att_rst),
        .push      (be_sts_valid),
        .push_word (be_sts_word),
        .pop       (rd_word),
        .full      (sts_full),
        .word      (sts_word),
        .ready     (be_sts_ready)
    );

    // interrupt latch; an abort completes with its own device and code
    logic              irq_done;
    logic [DEV_W-1:0]  irq_dev;
    logic [CODE_W-1:0] irq_code;
    logic [7:0]        int_byte;
    assign irq_done = be_done_valid || att_abort;
    assign irq_dev  = att_abort ? att_dev : dev_q;
    assign irq_code = att_abort ? CODE_DONE : be_done_code;

    dskif_intr u_intr (
        .clk       (clk),
        .rst       (rst),
        .flush     (att_rst),
        .done      (irq_done),
        .done_dev  (irq_dev),
        .done_code (irq_code),
        .eoi       (att_eoi),
        .int_en    (ctl_q[0]),
        .pend      (pend),
        .stat_byte (int_byte),
        .irq       (hst_irq)
    );

    always_ff @(posedge clk) begin
        if (rst || att_rst) begin
            busy_q <= 1'b0;
            dev_q  <= '0;
            ctl_q  <= '0;
            perr_q <= 1'b0;
        end else begin
            if (cmd_ok) begin
                busy_q <= 1'b1;
                dev_q  <= att_dev;
            end else if (att_abort) begin
                busy_q <= 1'b0;
            end else if (be_done_valid && (be_done_code != CODE_XFER_RDY)) begin
                busy_q <= 1'b0;
            end
            if (wr_ctrl)
                ctl_q <= hst_wdata[1:0];
            if (att_rej || cmd_drop)
                perr_q <= 1'b1;
        end
    end

    bstat_t bstat;
    always_comb begin
        bstat.dma_en   = ctl_q[1];
        bstat.int_pend = pend;
        bstat.cmd_prog = cmd_prog;
        bstat.busy     = busy_q;
        bstat.sts_full = sts_full;
        bstat.cmd_full = cmd_full;
        bstat.xfer_req = be_xfer_req;
        bstat.irq      = hst_irq;
    end

    always_comb begin
        unique case (hst_addr)
            OFS_WORD: hst_rdata = sts_word;
            OFS_CTRL: hst_rdata = WORD_W'(bstat);
            OFS_ATTN: hst_rdata = WORD_W'(int_byte);
            default:  hst_rdata = '0;
        endcase
    end

    assign hst_proto_err = perr_q;
    assign be_cmd_valid  = cmd_full;
    assign be_cmd_dev    = dev_q;
    assign be_abort      = att_abort;

    assert_att_block_R8: assert property (@(posedge clk) disable iff (rst)
        att_rej |=> hst_proto_err);

    assert_att_start_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_ok |=> (busy_q && cmd_prog && (be_cmd_dev == $past(att_dev))));

    assert_att_reset_R11: assert property (@(posedge clk) disable iff (rst)
        att_rst |=> (bstat[7:1] == '0 && !hst_proto_err && int_byte == '0));

    assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
        (att_abort && !att_rst) |=> (pend && !busy_q && !cmd_full && !cmd_prog));

endmodule

// File: tb/dskif_host_front_test.sv
`timescale 1ns/1ps
module dskif_host_front_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_sel = 0, hst_wr = 0;
    logic [1:0]  hst_addr = 0;
    logic [15:0] hst_wdata = 0;
    logic [15:0] hst_rdata;
    logic        hst_irq, hst_proto_err;
    logic        be_cmd_valid, be_cmd_first, be_cmd_last, be_abort, be_sts_ready;
    logic [15:0] be_cmd_word;
    logic [2:0]  be_cmd_dev;
    logic        be_cmd_take = 0, be_sts_valid = 0, be_done_valid = 0, be_xfer_req = 0;
    logic [15:0] be_sts_word = 0;
    logic [3:0]  be_done_code = 0;

    int errors = 0;
    int checks = 0;
    logic [15:0] rv;

    always #2.5 clk = ~clk;

    dskif_host_front uut (
        .clk(clk), .rst(rst), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_irq(hst_irq),
        .hst_proto_err(hst_proto_err), .be_cmd_valid(be_cmd_valid), .be_cmd_word(be_cmd_word),
        .be_cmd_first(be_cmd_first), .be_cmd_last(be_cmd_last), .be_cmd_dev(be_cmd_dev),
        .be_cmd_take(be_cmd_take), .be_abort(be_abort), .be_sts_valid(be_sts_valid),
        .be_sts_word(be_sts_word), .be_sts_ready(be_sts_ready), .be_done_valid(be_done_valid),
        .be_done_code(be_done_code), .be_xfer_req(be_xfer_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic hwr(input logic [1:0] a, input logic [15:0] d);
        hst_sel = 1; hst_wr = 1; hst_addr = a; hst_wdata = d;
        tick();
        hst_sel = 0; hst_wr = 0;
    endtask

    task automatic hrd(input logic [1:0] a, output logic [15:0] d);
        hst_sel = 1; hst_wr = 0; hst_addr = a;
        #1 d = hst_rdata;
        tick();
        hst_sel = 0;
    endtask

    task automatic be_take();
        be_cmd_take = 1; tick(); be_cmd_take = 0;
    endtask

    task automatic be_push(input logic [15:0] w);
        be_sts_valid = 1; be_sts_word = w; tick(); be_sts_valid = 0;
    endtask

    task automatic be_done(input logic [3:0] c);
        be_done_valid = 1; be_done_code = c; tick(); be_done_valid = 0;
    endtask

    task automatic bstat_is(input string req, input logic [7:0] exp);
        logic [15:0] v;
        hrd(2'd2, v);
        chk(req, v, {8'h00, exp});
    endtask

    // attention + all command words + back-end takes, with checks when verbose
    task automatic run_cmd(input logic [2:0] dev, input logic [15:0] op, input bit verbose);
        int n;
        n = (op[15:8] == 8'h46) ? 4 : 2;
        hwr(2'd3, {8'h00, dev, 5'h01});
        if (verbose) begin
            chk("R8 device latched", {13'd0, be_cmd_dev}, {13'd0, dev});
            bstat_is("R8 busy and in progress", 8'h30);
        end
        for (int k = 0; k < n; k++) begin
            logic [15:0] w;
            w = (k == 0) ? (op | {8'h00, dev, 5'h00}) : 16'(16'h1000 + k);
            hwr(2'd0, w);
            if (verbose) begin
                chk("R3 word presented", be_cmd_word, w);
                chk("R3 command full", {15'd0, be_cmd_valid}, 16'd1);
                chk("R4 first flag", {15'd0, be_cmd_first}, {15'd0, k == 0});
                chk("R4 last flag", {15'd0, be_cmd_last}, {15'd0, k == n - 1});
                bstat_is("R2 cmd full bit", 8'h34);
            end
            be_take();
            if (verbose)
                chk("R3 cleared by take", {15'd0, be_cmd_valid}, 16'd0);
        end
        if (verbose)
            bstat_is("R4 in progress ends after last word", 8'h10);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] ops [4];
        logic [2:0]  devs [3];
        ops[0] = 16'h4601; ops[1] = 16'h4602; ops[2] = 16'h0609; ops[3] = 16'h060A;
        devs[0] = 3'd0; devs[1] = 3'd1; devs[2] = 3'd7;

        tick(); tick();
        rst = 0;
        // R12 reset state
        bstat_is("R12 basic status after reset", 8'h00);
        hrd(2'd3, rv); chk("R12 int status after reset", rv, 16'h0000);
        chk("R12 irq low", {15'd0, hst_irq}, 16'd0);
        chk("R12 status ready", {15'd0, be_sts_ready}, 16'd1);

        // R1 spare offset
        hwr(2'd1, 16'hFFFF);
        hrd(2'd1, rv); chk("R1 offset 1 reads zero", rv, 16'h0000);
        bstat_is("R1 offset 1 write no effect", 8'h00);
        chk("R1 offset 1 no proto err", {15'd0, hst_proto_err}, 16'd0);

        // R2 / R7 DMA enable bit
        hwr(2'd2, 16'h0002);
        bstat_is("R7 dma enable bit7", 8'h80);
        hwr(2'd2, 16'h0000);
        be_xfer_req = 1;
        bstat_is("R2 transfer request bit1", 8'h02);
        be_xfer_req = 0;

        // sweep devices x opcodes
        for (int d = 0; d < 3; d++) begin
            for (int o = 0; o < 4; o++) begin
                logic [2:0] dv;
                dv = devs[d];
                run_cmd(dv, ops[o], 1'b1);
                for (int s = 0; s < 2; s++) begin
                    logic [15:0] sw;
                    sw = 16'(16'hA000 + d * 16 + o * 4 + s);
                    be_push(sw);
                    chk("R5 ready low when full", {15'd0, be_sts_ready}, 16'd0);
                    bstat_is("R5 status full bit", 8'h18);
                    hrd(2'd0, rv);
                    chk("R5 status word", rv, sw);
                    bstat_is("R5 read clears full", 8'h10);
                end
                if (ops[o][15:8] == 8'h46) begin
                    be_done(4'hB);
                    hrd(2'd3, rv); chk("R6 transfer-ready byte", rv, {8'h00, dv, 5'h0B});
                    bstat_is("R6 busy kept on 0x0B", 8'h50);
                end
                be_done(4'h1);
                hrd(2'd3, rv); chk("R6 completion byte", rv, {8'h00, dv, 5'h01});
                bstat_is("R6 pending, busy clear", 8'h40);
                hwr(2'd3, {8'h00, dv, 5'h02});
                bstat_is("R9 eoi clears pending", 8'h00);
                hrd(2'd3, rv); chk("R9 byte kept after eoi", rv, {8'h00, dv, 5'h01});
            end
        end
        chk("R3 no proto err in clean runs", {15'd0, hst_proto_err}, 16'd0);

        // R6 sweep all codes
        for (int c = 0; c < 16; c++) begin
            run_cmd(3'd1, 16'h0609, 1'b0);
            be_done(4'(c));
            hrd(2'd3, rv); chk("R6 code sweep byte", rv, 16'(16'h0020 | c));
            bstat_is("R6 code sweep busy", (c == 11) ? 8'h50 : 8'h40);
            if (c == 11) be_done(4'h1);
            hwr(2'd3, 16'h0022);
        end

        // R7 gating sweep while pending
        run_cmd(3'd0, 16'h0609, 1'b0);
        be_done(4'h1);
        for (int g = 0; g < 4; g++) begin
            hwr(2'd2, 16'(g));
            chk("R7 irq follows enable", {15'd0, hst_irq}, {15'd0, g[0]});
            bstat_is("R7 status with enable", {g[1], 1'b1, 5'b0, g[0]});
        end
        hwr(2'd2, 16'h0000);
        chk("R7 write zero drops line", {15'd0, hst_irq}, 16'd0);
        hwr(2'd2, 16'h0001);
        chk("R7 line back up", {15'd0, hst_irq}, 16'd1);

        // R8 refused while pending
        hwr(2'd3, 16'h0001);
        bstat_is("R8 refused request leaves state", 8'h41);
        chk("R8 proto err on refusal", {15'd0, hst_proto_err}, 16'd1);
        hwr(2'd3, 16'h0002);
        chk("R9 eoi drops line", {15'd0, hst_irq}, 16'd0);
        hwr(2'd3, 16'h00E4);
        chk("R11 proto err cleared", {15'd0, hst_proto_err}, 16'd0);
        bstat_is("R11 control cleared", 8'h00);

        // R8 refused while busy
        hwr(2'd3, 16'h0021);
        hwr(2'd3, 16'h0041);
        chk("R8 proto err while busy", {15'd0, hst_proto_err}, 16'd1);
        chk("R8 device kept while busy", {13'd0, be_cmd_dev}, 16'd1);
        hwr(2'd3, 16'h00E4);

        // R3 drop with no command in progress
        hwr(2'd0, 16'h4601);
        chk("R3 no word without command", {15'd0, be_cmd_valid}, 16'd0);
        chk("R3 proto err on stray word", {15'd0, hst_proto_err}, 16'd1);
        hwr(2'd3, 16'h00E4);
        // R3 drop while full
        hwr(2'd3, 16'h0001);
        hwr(2'd0, 16'h4601);
        hwr(2'd0, 16'h5555);
        chk("R3 held word kept", be_cmd_word, 16'h4601);
        chk("R3 proto err on overrun", {15'd0, hst_proto_err}, 16'd1);

        // R10 abort mid-command
        hst_sel = 1; hst_wr = 1; hst_addr = 2'd3; hst_wdata = 16'h0023;
        #1 chk("R10 abort pulse", {15'd0, be_abort}, 16'd1);
        tick(); hst_sel = 0; hst_wr = 0;
        chk("R10 command flushed", {15'd0, be_cmd_valid}, 16'd0);
        bstat_is("R10 abort completes", 8'h40);
        hrd(2'd3, rv); chk("R10 abort byte", rv, 16'h0021);
        hwr(2'd3, 16'h0022);
        hwr(2'd3, 16'h0001);
        bstat_is("R10 new command after abort", 8'h30);

        // R11 full reset attention
        hwr(2'd2, 16'h0003);
        hwr(2'd0, 16'h0609);
        be_push(16'hBEEF);
        be_done(4'h1);
        bstat_is("R11 setup state", 8'hED);
        hwr(2'd3, 16'h00E4);
        bstat_is("R11 all flags zero", 8'h00);
        hrd(2'd3, rv); chk("R11 int byte zero", rv, 16'h0000);
        chk("R11 status ready", {15'd0, be_sts_ready}, 16'd1);

        // R12 synchronous reset mid-operation
        run_cmd(3'd1, 16'h4601, 1'b0);
        be_push(16'h1234);
        rst = 1; tick(); rst = 0;
        bstat_is("R12 reset mid-operation", 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule